// File: doc/BRIEF.md
# Fault-Tolerant Vector Load Sequencer

This block runs one vector load as a series of single-element memory reads. A caller gives a base address, an element size, a requested element count and the index of the first destination register. The sequencer then walks the elements in order. It issues one read, waits for its response, writes the returned data into the next destination register and moves on to the following element.

The memory port reports a fault flag with every response. The first element is mandatory. If it faults, the load ends with a trap indication and nothing is written. If any later element faults, the load does not trap. It stops at that element and reports how many elements were actually loaded, so the caller can shorten its vector length and carry on. Both kinds of ending, and a normal full completion, finish with a single-cycle done pulse. The pulse carries the final count.

Top module: `vld_seq`

## Requirements
- R1: While `rst_ni` is low, `busy_o`, `done_o`, `trap_o`, `mem_req_o` and `rf_we_o` are 0 and `loaded_o` is 0.
- R2: The address of element i is `base_addr_i + i * (1 << esize_i)`. The element size field uses the codes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes.
- R3: At most one read is outstanding. After `mem_req_o` is high for one cycle, no new request is made until `mem_rsp_valid_i` has been seen. After a good response that is not the last, the next request follows in the next cycle.
- R4: A response without a fault for element i drives `rf_we_o` in the cycle of the response. In that cycle `rf_waddr_o = dest_base_i + i` (modulo the register index width) and `rf_wdata_o` is the response data.
- R5: When every requested element returns without a fault, `done_o` pulses in the cycle after the last response, with `loaded_o` equal to the requested count and `trap_o` low.
- R6: A fault on element k, with k >= 1, ends the load. No write is made for element k, no further request is issued, and `done_o` pulses with `loaded_o = k` and `trap_o = 0`.
- R7: A fault on element 0 raises `trap_o` together with `done_o`, with `loaded_o = 0` and no register write.
- R8: A requested count of 0 pulses `done_o` in the cycle after the start, with `loaded_o = 0` and no memory request.
- R9: `done_o` is high for exactly one cycle per load. `loaded_o` holds its value until the next accepted start.
- R10: `start_i` has no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a load (accepted only when idle) |
| base_addr_i | input | ADDR_W | Byte address of element 0 |
| esize_i | input | 2 | Element size code (0..3 gives 1, 2, 4 or 8 bytes) |
| count_i | input | CNT_W | Requested element count |
| dest_base_i | input | RIDX_W | Destination register for element 0 |
| mem_req_o | output | 1 | Read request, one-cycle pulse |
| mem_addr_o | output | ADDR_W | Read address |
| mem_rsp_valid_i | input | 1 | Response valid |
| mem_rsp_data_i | input | DATA_W | Response data |
| mem_rsp_fault_i | input | 1 | Response faulted |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | RIDX_W | Register write index |
| rf_wdata_o | output | DATA_W | Register write data |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load finished, one-cycle pulse |
| trap_o | output | 1 | First element faulted (valid with done_o) |
| loaded_o | output | CNT_W | Number of elements loaded |

## Verification
A request appears the cycle after the start or after the previous good response. A register write is combinational with the response, so the bench samples `rf_we_o` one time step after it drives the response, while that response is still held. `done_o`, `trap_o` and `loaded_o` are due one edge after the final response, or one edge after a zero-count start. The bench samples them at the next falling edge and checks one falling edge later that the pulse is gone and the count is still held. Response latency is drawn at random from one to three cycles, so no check relies on a fixed distance between request and response.

// File: rtl/vld_pkg.sv
package vld_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_FIN
  } st_e;
endpackage

// File: rtl/vld_addr_gen.sv
module vld_addr_gen #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [1:0]        esize_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        sz_q;
  logic [ADDR_W-1:0] stride;

  assign stride = ADDR_W'(1) << sz_q;

  // running address: one adder instead of an index multiplier
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      sz_q   <= '0;
    end else if (load_i) begin
      addr_q <= base_i;
      sz_q   <= esize_i;
    end else if (step_i) begin
      addr_q <= addr_q + stride;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/vld_wb.sv
module vld_wb #(
  parameter int DATA_W = 64,
  parameter int RIDX_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [RIDX_W-1:0] dest_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              we_o,
  output logic [RIDX_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic [RIDX_W-1:0] waddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      waddr_q <= '0;
    else if (load_i)  waddr_q <= dest_i;
    else if (step_i)  waddr_q <= waddr_q + RIDX_W'(1);
  end

  assign we_o    = step_i;
  assign waddr_o = waddr_q;
  assign wdata_o = data_i;
endmodule

// File: rtl/vld_fsm.sv
module vld_fsm
  import vld_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             rsp_valid_i,
  input  logic             rsp_fault_i,
  output st_e              state_o,
  output logic             load_o,
  output logic             step_o,
  output logic [CNT_W-1:0] loaded_o,
  output logic             trap_o,
  output logic             done_o
);
  st_e              st_q, st_d;
  logic [CNT_W-1:0] idx_q, cnt_q, loaded_q;
  logic             trap_q;
  logic             accept, good, bad, last;

  assign accept = (st_q == ST_IDLE) && start_i;
  assign good   = (st_q == ST_WAIT) && rsp_valid_i && !rsp_fault_i;
  assign bad    = (st_q == ST_WAIT) && rsp_valid_i && rsp_fault_i;
  assign last   = (idx_q + CNT_W'(1)) == cnt_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = (count_i == '0) ? ST_FIN : ST_REQ;
      ST_REQ:  st_d = ST_WAIT;
      ST_WAIT: if (rsp_valid_i) st_d = (rsp_fault_i || last) ? ST_FIN : ST_REQ;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      cnt_q    <= '0;
      loaded_q <= '0;
      trap_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        idx_q    <= '0;
        cnt_q    <= count_i;
        loaded_q <= '0;
        trap_q   <= 1'b0;
      end else if (good) begin
        idx_q <= idx_q + CNT_W'(1);
        if (last) loaded_q <= cnt_q;
      end else if (bad) begin
        // element 0 is mandatory: trap instead of truncating
        loaded_q <= idx_q;
        trap_q   <= (idx_q == '0);
      end
    end
  end

  assign state_o  = st_q;
  assign load_o   = accept;
  assign step_o   = good;
  assign loaded_o = loaded_q;
  assign done_o   = (st_q == ST_FIN);
  assign trap_o   = (st_q == ST_FIN) && trap_q;
endmodule

// File: rtl/vld_seq.sv
module vld_seq
  import vld_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 5,
  parameter int RIDX_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [1:0]        esize_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [RIDX_W-1:0] dest_base_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i,
  input  logic              mem_rsp_fault_i,
  output logic              rf_we_o,
  output logic [RIDX_W-1:0] rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              trap_o,
  output logic [CNT_W-1:0]  loaded_o
);
  st_e  state;
  logic load, step;

  vld_fsm #(.CNT_W(CNT_W)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .count_i     (count_i),
    .rsp_valid_i (mem_rsp_valid_i),
    .rsp_fault_i (mem_rsp_fault_i),
    .state_o     (state),
    .load_o      (load),
    .step_o      (step),
    .loaded_o    (loaded_o),
    .trap_o      (trap_o),
    .done_o      (done_o)
  );

  vld_addr_gen #(.ADDR_W(ADDR_W)) i_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .base_i  (base_addr_i),
    .esize_i (esize_i),
    .step_i  (step),
    .addr_o  (mem_addr_o)
  );

  vld_wb #(.DATA_W(DATA_W), .RIDX_W(RIDX_W)) i_wb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .dest_i  (dest_base_i),
    .step_i  (step),
    .data_i  (mem_rsp_data_i),
    .we_o    (rf_we_o),
    .waddr_o (rf_waddr_o),
    .wdata_o (rf_wdata_o)
  );

  assign mem_req_o = (state == ST_REQ);
  assign busy_o    = (state != ST_IDLE);
endmodule

// File: rtl/vld_seq_chk.sv
module vld_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] base_addr_i,
  input logic [1:0]        esize_i,
  input logic [CNT_W-1:0]  count_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rsp_valid_i,
  input logic              mem_rsp_fault_i,
  input logic              rf_we_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              trap_o,
  input logic [CNT_W-1:0]  loaded_o
);
  logic              accept;
  logic              first_q, out_q;
  logic [1:0]        sz_q;
  logic [ADDR_W-1:0] exp_a_q;
  logic [CNT_W-1:0]  cnt_q;

  assign accept = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b0;
      out_q   <= 1'b0;
      sz_q    <= '0;
      exp_a_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (accept) begin
        first_q <= 1'b1;
        sz_q    <= esize_i;
        exp_a_q <= base_addr_i;
        cnt_q   <= count_i;
      end else if (mem_req_o) begin
        first_q <= 1'b0;
        exp_a_q <= mem_addr_o + (ADDR_W'(1) << sz_q);
      end
      if (mem_req_o)            out_q <= 1'b1;
      else if (mem_rsp_valid_i) out_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_R1: assert (!busy_o && !done_o && !trap_o && !mem_req_o && !rf_we_o && loaded_o == '0)
        else $error("reset state");
    end
  end

  assert_addr_stride_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o == exp_a_q);

  assert_one_outstanding_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q |-> !mem_req_o);

  assert_loaded_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> loaded_o <= cnt_q);

  assert_no_write_on_fault_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rsp_valid_i && mem_rsp_fault_i) |-> !rf_we_o);

  assert_trap_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (done_o && loaded_o == '0));

  assert_zero_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && count_i == '0) |=> (done_o && loaded_o == '0 && !mem_req_o));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  unused_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && first_q) |-> !out_q);
endmodule

bind vld_seq vld_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_vld_seq.sv
module test_vld_seq;
  localparam int AW = 32, DW = 64, CW = 5, RW = 5;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base = '0;
  logic [1:0]    esize = '0;
  logic [CW-1:0] count = '0;
  logic [RW-1:0] dest = '0;
  logic          req;
  logic [AW-1:0] addr;
  logic          rvalid = 1'b0, rfault = 1'b0;
  logic [DW-1:0] rdata = '0;
  logic          we;
  logic [RW-1:0] waddr;
  logic [DW-1:0] wdata;
  logic          busy, done, trap;
  logic [CW-1:0] loaded;

  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  vld_seq i_vld_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base), .esize_i(esize),
    .count_i(count), .dest_base_i(dest), .mem_req_o(req), .mem_addr_o(addr),
    .mem_rsp_valid_i(rvalid), .mem_rsp_data_i(rdata), .mem_rsp_fault_i(rfault),
    .rf_we_o(we), .rf_waddr_o(waddr), .rf_wdata_o(wdata), .busy_o(busy),
    .done_o(done), .trap_o(trap), .loaded_o(loaded)
  );

  function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
    return {a ^ 32'h5a5a_0f0f, ~a};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // fault_at < 0 : no fault
  task automatic run_op(input logic [AW-1:0] b, input logic [CW-1:0] c, input logic [1:0] sz,
                        input logic [RW-1:0] d, input int fault_at, input bit poke);
    int k, exp_reqs, reqs, writes, dones, wait_n, iter;
    bit pending, exp_trap, got_trap, fin;
    logic [AW-1:0] cur_a;
    logic [CW-1:0] got_loaded;
    string rq;
    if (fault_at < 0 || fault_at >= int'(c)) begin k = int'(c); exp_reqs = int'(c); end
    else begin k = fault_at; exp_reqs = fault_at + 1; end
    exp_trap = (fault_at == 0) && (c != 0);
    rq = exp_trap ? "R7" : (k < int'(c)) ? "R6" : (c == 0) ? "R8" : "R5";
    reqs = 0; writes = 0; dones = 0; pending = 0; wait_n = 0; fin = 0;
    got_trap = 0; got_loaded = '0; cur_a = '0;
    @(negedge clk);
    base = b; count = c; esize = sz; dest = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (c == 0) chk(done === 1'b1, "R8", "done one cycle after zero-count start", done, 1);
    for (iter = 0; iter < 400 && !fin; iter++) begin
      if (iter > 0) @(negedge clk);
      rvalid = 1'b0; rfault = 1'b0;
      if (poke && iter == 1) begin
        count = 5'd1; base = 32'hdead_0000; start = 1'b1;
      end else start = 1'b0;
      if (done) begin
        dones++; got_trap = trap; got_loaded = loaded; fin = 1;
      end
      if (req) begin
        chk(!pending, "R3", "request while one outstanding", 1, 0);
        chk(addr == b + (AW'(reqs) << sz), "R2", "element address", addr, b + (AW'(reqs) << sz));
        cur_a = addr; reqs++; pending = 1; wait_n = $urandom_range(1, 3);
      end else if (pending) begin
        wait_n--;
        if (wait_n == 0) begin
          pending = 0;
          rvalid = 1'b1; rdata = mem_fn(cur_a); rfault = (reqs - 1 == fault_at);
          #1;
          if (rfault) chk(we === 1'b0, rq, "write on faulting element", we, 0);
          else begin
            chk(we === 1'b1, "R4", "write enable with good response", we, 1);
            chk(waddr == RW'(int'(d) + writes), "R4", "write index", waddr, RW'(int'(d) + writes));
            chk(wdata == mem_fn(cur_a), "R4", "write data", wdata, mem_fn(cur_a));
            writes++;
          end
        end
      end
    end
    start = 1'b0;
    chk(fin, rq, "load finished", fin, 1);
    chk(dones == 1, rq, "done pulses", dones, 1);
    chk(got_loaded == CW'(k), poke ? "R10" : rq, "loaded count", got_loaded, k);
    chk(got_trap == exp_trap, rq, "trap flag", got_trap, exp_trap);
    chk(reqs == exp_reqs, poke ? "R10" : rq, "request count", reqs, exp_reqs);
    chk(writes == k, rq, "register writes", writes, k);
    @(negedge clk);
    chk(done === 1'b0, "R9", "done drops after one cycle", done, 0);
    chk(loaded == CW'(k), "R9", "loaded held", loaded, k);
    chk(busy === 1'b0, "R9", "idle after done", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #5;
    chk(busy === 0 && done === 0 && trap === 0 && req === 0 && we === 0 && loaded === '0,
        "R1", "reset outputs", {busy, done, trap, req, we}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run_op(32'h0000_1000, 5'd4, 2'd3, 5'd2, -1, 0);   // R5 full
    run_op(32'h0000_2001, 5'd6, 2'd1, 5'd8, 2, 0);    // R6 truncate at 2
    run_op(32'h0000_3000, 5'd5, 2'd2, 5'd0, 0, 0);    // R7 trap
    run_op(32'h0000_4000, 5'd0, 2'd0, 5'd3, -1, 0);   // R8 zero
    run_op(32'h0000_5000, 5'd1, 2'd0, 5'd9, -1, 0);   // single element
    run_op(32'h0000_6000, 5'd31, 2'd0, 5'd30, -1, 0); // R4 dest wrap
    run_op(32'h0000_7000, 5'd8, 2'd3, 5'd1, 7, 0);    // R6 fault on last
    run_op(32'h0000_8000, 5'd3, 2'd2, 5'd4, -1, 1);   // R10 start while busy
    for (int i = 0; i < 40; i++) begin
      logic [CW-1:0] c;
      int f;
      c = CW'($urandom_range(0, 12));
      f = ($urandom_range(0, 2) == 0) ? -1 : int'($urandom_range(0, 12));
      run_op($urandom, c, 2'($urandom_range(0, 3)), RW'($urandom), f, 0);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule